// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Controller

This block holds the interrupt status word and the DMA control word of an Ethernet DMA engine. Single-cycle event pulses from the transmit side, the receive side and the memory interface are captured into sticky status bits. Software clears each bit by writing a one to it. The status bits are combined with enable fields from the control word to drive one interrupt line. Events that corrupt the data stream (memory error, transmit abort, receive overflow) switch off both DMA enables at once.

The status word also carries live, read-only copies of the receive read pointer, the transmit read pointer and the sequence number of the frame at the head of the receive queue. Software can therefore read pointers and causes in one access. A receive threshold bit is raised whenever the receive FIFO occupancy differs from a depth programmed in the control word.

Register access is one write port and one combinational read port, each with a select line: 0 selects the status word and 1 selects the control word. There is no data stream through the block, so every pin is a plain control or status signal and none uses valid/ready flow control.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After reset, every status bit is zero, the control word reads zero, `irq` is low and both DMA enables are low.
- R2: Each event pulse sets its own sticky status bit on the next clock edge: bit 0 transmit ring empty, bit 1 transmitted packet requested an interrupt, bit 2 link failure, bit 3 memory error, bit 4 transmit abort, bit 6 receive underflow, bit 7 receive overflow.
- R3: A status write clears each of bits 7:0 where the written data is one and leaves bits written with zero unchanged.
- R4: An event pulse in the same cycle as a write that clears the same bit leaves that bit set.
- R5: A memory error, transmit abort or receive overflow event clears the transmit enable (control bit 1) and the receive enable (control bit 15) on the next edge. This overrides a control write in the same cycle. The enables stay low until software writes them again, and all other control fields are kept.
- R6: `irq` is high exactly when one of these holds: bit 0 or bit 1 is set and transmit interrupt enable (control bit 0) is one; bit 5 is set and receive interrupt enable (control bit 9) is one; or any of bits 2, 3, 4, 6 or 7 is set, with no enable needed.
- R7: Status bit 5 is set on the edge after any cycle in which `rx_fifo_count` differs from the depth field (control bits 8:4). While the two are equal it stays clear once cleared.
- R8: The status word shows `rx_rptr` at bits 11:8, `tx_rptr` at bits 24:16 and `rx_head_seq` at bits 29:25, live and without delay. Bits 15:12, 31 and 30 read zero.
- R9: The control word is written and read back through select 1 with these fields: bit 0 transmit interrupt enable, bit 1 transmit enable, bits 8:4 depth, bit 9 receive interrupt enable, bits 14:12 receive data offset, bit 15 receive enable. All other bits read zero. `dma_tx_en`, `dma_rx_en` and `rx_data_offset` follow the stored fields.
- R10: Writing ones to the status word's pointer and sequence positions (bits 31:8) has no effect on what those positions read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 control |
| rd_data | output | 32 | Combinational read data |
| ev_tx_empty | input | 1 | Transmit ring empty pulse |
| ev_tx_pkt | input | 1 | Interrupt-requesting packet sent pulse |
| ev_link_fail | input | 1 | PHY link failure pulse |
| ev_mem_err | input | 1 | DMA memory error pulse (fatal) |
| ev_tx_abort | input | 1 | Transmit abort pulse (fatal) |
| ev_rx_underflow | input | 1 | Receive FIFO empty, frame dropped pulse |
| ev_rx_overflow | input | 1 | Receive DMA FIFO overflow pulse (fatal) |
| rx_fifo_count | input | 5 | Current receive FIFO occupancy |
| rx_rptr | input | 4 | Receive read pointer |
| tx_rptr | input | 9 | Transmit read pointer |
| rx_head_seq | input | 5 | Sequence number of frame at queue head |
| irq | output | 1 | Interrupt line |
| dma_tx_en | output | 1 | Transmit DMA enable |
| dma_rx_en | output | 1 | Receive DMA enable |
| rx_data_offset | output | 3 | Receive data start offset |

## Verification
A sticky bit that fails to set or clear shows up on the status read one clock after the pulse or the write. If it is an error-group bit, the interrupt line is wrong in that same cycle. A fatal event that does not reach the control register leaves `dma_tx_en` or `dma_rx_en` high on the edge after the event, and nothing later corrects it. The enable gating and the wrong-bit mixing of the alias fields can only be seen by comparing the read word and `irq` against values worked out independently for each combination of status bits and enables.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_EV     = 8;
  localparam int CTRL_W     = 16;
  localparam int RXPTR_W    = 4;
  localparam int TXPTR_W    = 9;
  localparam int SEQ_W      = 5;
  localparam int DEPTH_W    = 5;
  localparam int OFF_W      = 3;

  // status bit positions
  localparam int S_TX_EMPTY = 0;
  localparam int S_TX_PKT   = 1;
  localparam int S_LINK     = 2;
  localparam int S_MEM      = 3;
  localparam int S_TX_ABORT = 4;
  localparam int S_RX_THR   = 5;
  localparam int S_RX_UNDER = 6;
  localparam int S_RX_OVER  = 7;

  localparam int RXPTR_LSB  = 8;
  localparam int TXPTR_LSB  = 16;
  localparam int SEQ_LSB    = 25;

  localparam logic [NUM_EV-1:0] ERR_MASK   = 8'b1101_1100;
  localparam logic [NUM_EV-1:0] TX_MASK    = 8'b0000_0011;
  localparam logic [NUM_EV-1:0] FATAL_MASK = 8'b1001_1000;

  // control word, fields at their decoded positions
  typedef struct packed {
    logic               rx_en;    // 15
    logic [OFF_W-1:0]   rx_off;   // 14:12
    logic [1:0]         zero_hi;  // 11:10
    logic               rx_ie;    // 9
    logic [DEPTH_W-1:0] depth;    // 8:4
    logic [1:0]         zero_lo;  // 3:2
    logic               tx_en;    // 1
    logic               tx_ie;    // 0
  } ctrl_t;
endpackage

// File: rtl/irq_sticky_bits.sv
module irq_sticky_bits #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] bits_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        bits_o[i] <= 1'b0;
      else if (set_i[i]) bits_o[i] <= 1'b1;
      else if (clr_i[i]) bits_o[i] <= 1'b0;
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> bits_o[i]); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !bits_o[i]); // R3
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bits_o[i] && !set_i[i]) |=> !bits_o[i]); // R2
  end
endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl
  import mac_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              fatal_i,
  output ctrl_t             ctrl_o
);
  ctrl_t nxt;

  always_comb begin
    nxt = ctrl_o;
    if (wr_i) begin
      nxt = ctrl_t'(wdata_i);
      nxt.zero_hi = '0;
      nxt.zero_lo = '0;
    end
    if (fatal_i) begin
      nxt.tx_en = 1'b0;
      nxt.rx_en = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_o <= '0;
    else        ctrl_o <= nxt;
  end

  AST_FATAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_i |=> (!ctrl_o.tx_en && !ctrl_o.rx_en)); // R5
  AST_EN_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !ctrl_o.tx_en) |=> !ctrl_o.tx_en); // R5
  AST_RSVD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ctrl_o.zero_hi == 2'b00 && ctrl_o.zero_lo == 2'b00)); // R9
endmodule

// File: rtl/irq_rx_thresh.sv
module irq_rx_thresh #(
  parameter int DEPTH_W = 5
) (
  input  logic [DEPTH_W-1:0] count_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               hit_o
);
  always_comb hit_o = (count_i != depth_i);
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
  import mac_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                ev_tx_empty,
  input  logic                ev_tx_pkt,
  input  logic                ev_link_fail,
  input  logic                ev_mem_err,
  input  logic                ev_tx_abort,
  input  logic                ev_rx_underflow,
  input  logic                ev_rx_overflow,
  input  logic [DEPTH_W-1:0]  rx_fifo_count,
  input  logic [RXPTR_W-1:0]  rx_rptr,
  input  logic [TXPTR_W-1:0]  tx_rptr,
  input  logic [SEQ_W-1:0]    rx_head_seq,
  output logic                irq,
  output logic                dma_tx_en,
  output logic                dma_rx_en,
  output logic [OFF_W-1:0]    rx_data_offset
);
  logic [NUM_EV-1:0] ev_vec, clr_vec, st;
  logic              thr_hit, fatal;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] stat_word;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:CTRL_W];

  irq_rx_thresh #(.DEPTH_W(DEPTH_W)) u_thr (
    .count_i(rx_fifo_count), .depth_i(ctrl.depth), .hit_o(thr_hit)
  );

  always_comb begin
    ev_vec             = '0;
    ev_vec[S_TX_EMPTY] = ev_tx_empty;
    ev_vec[S_TX_PKT]   = ev_tx_pkt;
    ev_vec[S_LINK]     = ev_link_fail;
    ev_vec[S_MEM]      = ev_mem_err;
    ev_vec[S_TX_ABORT] = ev_tx_abort;
    ev_vec[S_RX_THR]   = thr_hit;
    ev_vec[S_RX_UNDER] = ev_rx_underflow;
    ev_vec[S_RX_OVER]  = ev_rx_overflow;
    clr_vec = (wr_en && !wr_sel) ? wr_data[NUM_EV-1:0] : '0;
    fatal   = |(ev_vec & FATAL_MASK);
  end

  irq_sticky_bits #(.N(NUM_EV)) u_bits (
    .clk(clk), .rst_n(rst_n), .set_i(ev_vec), .clr_i(clr_vec), .bits_o(st)
  );

  irq_dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en && wr_sel),
    .wdata_i(wr_data[CTRL_W-1:0]), .fatal_i(fatal), .ctrl_o(ctrl)
  );

  always_comb begin
    stat_word = '0;
    stat_word[NUM_EV-1:0] = st;
    stat_word[RXPTR_LSB +: RXPTR_W] = rx_rptr;
    stat_word[TXPTR_LSB +: TXPTR_W] = tx_rptr;
    stat_word[SEQ_LSB   +: SEQ_W]   = rx_head_seq;
    rd_data = rd_sel ? {{(DATA_W-CTRL_W){1'b0}}, ctrl} : stat_word;
    irq = (|(st & TX_MASK) && ctrl.tx_ie)
        || (st[S_RX_THR] && ctrl.rx_ie)
        || |(st & ERR_MASK);
    dma_tx_en      = ctrl.tx_en;
    dma_rx_en      = ctrl.rx_en;
    rx_data_offset = ctrl.rx_off;
  end

  AST_ERR_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st & ERR_MASK)) |-> irq); // R6
  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == '0) |-> !irq); // R6
  AST_THR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_count != ctrl.depth) |=> st[S_RX_THR]); // R7
  AST_ALIAS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rd_data[11:8] == rx_rptr && rd_data[24:16] == tx_rptr
                 && rd_data[29:25] == rx_head_seq)); // R8
endmodule

// File: tb/mac_irq_ctrl_tb.sv
`timescale 1ns/1ps
module mac_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic ev_tx_empty = 0, ev_tx_pkt = 0, ev_link_fail = 0, ev_mem_err = 0;
  logic ev_tx_abort = 0, ev_rx_underflow = 0, ev_rx_overflow = 0;
  logic [4:0] rx_fifo_count = '0;
  logic [3:0] rx_rptr = '0;
  logic [8:0] tx_rptr = '0;
  logic [4:0] rx_head_seq = '0;
  logic irq, dma_tx_en, dma_rx_en;
  logic [2:0] rx_data_offset;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] alias_w;

  always #2.5 clk = ~clk;

  mac_irq_ctrl u_dut (.*);

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; tick(); wr_en = 0; wr_data = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 status", v, 32'h0);
    rd(1, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq/en", {irq, dma_tx_en, dma_rx_en}, 3'b000);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    rx_rptr = 4'hA; tx_rptr = 9'h1C5; rx_head_seq = 5'h13;
    alias_w = (32'hA << 8) | (32'h1C5 << 16) | (32'h13 << 25);
    rd(0, v); chk("R8 alias", v, alias_w);
    wr(0, 32'hFFFF_FF00);
    rd(0, v); chk("R10 alias write ignored", v, alias_w);
  endtask

  task automatic t_tx_bits();
    logic [31:0] v;
    ev_tx_empty = 1; tick(); ev_tx_empty = 0;
    rd(0, v); chk("R2 tx empty bit0", v, alias_w | 32'h1);
    chk("R6 tx gated off", irq, 1'b0);
    wr(1, 32'h1);
    chk("R6 tx gated on", irq, 1'b1);
    wr(0, 32'h0);
    rd(0, v); chk("R3 write zero keeps", v, alias_w | 32'h1);
    wr(0, 32'h1);
    rd(0, v); chk("R3 write one clears", v, alias_w);
    chk("R6 irq drops", irq, 1'b0);
    ev_tx_pkt = 1; wr_en = 1; wr_sel = 0; wr_data = 32'h2; tick();
    ev_tx_pkt = 0; wr_en = 0;
    rd(0, v); chk("R4 event beats clear", v, alias_w | 32'h2);
    wr(0, 32'h2);
    wr(1, 32'h0);
  endtask

  task automatic t_nonfatal();
    logic [31:0] v;
    wr(1, 32'hF203);
    ev_link_fail = 1; tick(); ev_link_fail = 0;
    rd(0, v); chk("R2 link bit2", v, alias_w | 32'h4);
    chk("R6 link ungated", irq, 1'b1);
    wr(0, 32'h4);
    ev_rx_underflow = 1; tick(); ev_rx_underflow = 0;
    rd(0, v); chk("R2 underflow bit6", v, alias_w | 32'h40);
    rd(1, v); chk("R5 underflow not fatal", v, 32'hF203);
    chk("R6 underflow ungated", irq, 1'b1);
    wr(0, 32'h40);
  endtask

  task automatic t_fatal();
    logic [31:0] v;
    for (int k = 0; k < 3; k++) begin
      wr(1, 32'hF203);
      chk("R9 enables out", {dma_tx_en, dma_rx_en, rx_data_offset}, 5'b11111);
      case (k)
        0: ev_mem_err = 1;
        1: ev_tx_abort = 1;
        default: ev_rx_overflow = 1;
      endcase
      tick();
      ev_mem_err = 0; ev_tx_abort = 0; ev_rx_overflow = 0;
      rd(1, v); chk("R5 fatal clears enables", v, 32'h7201);
      chk("R5 enable pins low", {dma_tx_en, dma_rx_en}, 2'b00);
      rd(0, v);
      chk("R2 fatal bit", v, alias_w | (k == 0 ? 32'h8 : k == 1 ? 32'h10 : 32'h80));
      chk("R6 fatal irq", irq, 1'b1);
      tick();
      chk("R5 enables stay low", {dma_tx_en, dma_rx_en}, 2'b00);
      wr(0, 32'hFF);
    end
    ev_mem_err = 1; wr_en = 1; wr_sel = 1; wr_data = 32'h8002; tick();
    ev_mem_err = 0; wr_en = 0;
    rd(1, v); chk("R5 fatal beats write", v, 32'h0);
    wr(0, 32'hFF);
    wr(1, 32'h8002);
    chk("R5 re-enable by write", {dma_tx_en, dma_rx_en}, 2'b11);
    wr(1, 32'hFFFF);
    rd(1, v); chk("R9 reserved ctrl zero", v, 32'hF3F3);
    wr(1, 32'h0);
    wr(0, 32'hFF);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    wr(1, 32'h230);
    rx_fifo_count = 5'd3; tick();
    wr(0, 32'h20);
    rd(0, v); chk("R7 equal stays clear", v, alias_w);
    chk("R7 irq low when equal", irq, 1'b0);
    rx_fifo_count = 5'd2; tick();
    rd(0, v); chk("R7 differs sets bit5", v, alias_w | 32'h20);
    chk("R6 rx gated on", irq, 1'b1);
    wr(1, 32'h030);
    chk("R6 rx gated off", irq, 1'b0);
    rx_fifo_count = 5'd3; tick();
    wr(0, 32'h20);
    rd(0, v); chk("R7 cleared", v, alias_w);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    t_reset();
    t_alias();
    t_tx_bits();
    t_nonfatal();
    t_fatal();
    t_thresh();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule